// File: doc/BRIEF.md
# Multiplexer Readout Sequencer

This block drives the readout of a daisy chain of analog multiplexer front-end chips once a trigger has been seen. A run moves a token into the chain's shift register, clocks the chain with two non-overlapping shift clocks, and fires analog-to-digital conversion strobes at a chosen point in every clock tick. Each conversion strobe is followed by a write strobe for the buffer that stores the converted sample. A `busy` flag covers the whole run.

Four run parameters are loaded as a fixed frame of five bytes over an asynchronous serial line (8N1, idle high). These are the tick period, the number of ticks (one per strip), the conversion delay after the tick edge, and the number of conversions per tick. A new frame takes effect only between runs. The strobes are push-only pulses. They carry no back-pressure, so the buffer must take one write every two clock cycles at most.

Top module: `mux_readout_seq`

## Requirements
- R1: The serial input is 8N1 with the least significant bit first, idle high, and `CLKS_PER_BIT` clock cycles per bit. A byte whose stop bit reads low is dropped, and the frame then restarts at byte 0.
- R2: Frame bytes in arrival order are: byte 0 is the tick interval in clock cycles; byte 1 is the low 8 bits of the tick count; byte 2 bits [2:0] are the tick count bits [10:8], and its bits [7:3] are ignored; byte 3 is the conversion delay in cycles; byte 4 is the conversions per tick.
- R3: A frame replaces the active parameters only after its fifth byte and only while no run is active. A run in progress finishes with the parameters it started with.
- R4: A rising edge on `trig` while idle starts a run, and `busy` goes high after the second rising clock edge from the one that samples the trigger. A trigger edge during a run is ignored. A tick count of zero makes every trigger ignored.
- R5: The tick period P in cycles is the largest of the programmed interval, 8, and delay + 2 × (conversions per tick).
- R6: Let t be the cycle within a tick (0 to P−1). `mux_token` is high for t < P/2 (rounded down) in the first tick only.
- R7: `mux_phi1` is high for 1 ≤ t < P/2, and `mux_phi2` is high for P/2+1 ≤ t ≤ P−1. They are never high together, and each falling phase is followed by a cycle with both low.
- R8: `adc_conv` pulses for one cycle at t = delay + 2k for k = 0 to S−1. S is the programmed conversions per tick, with 0 taken as 1 and values above 8 taken as 8.
- R9: `fifo_wr` pulses exactly one cycle after every `adc_conv` pulse and at no other time.
- R10: `busy` stays high for exactly count × P cycles. All strobe outputs are low while `busy` is low.
- R11: After reset the outputs are low and the active parameters are interval 8, count 128, delay 2 and one conversion per tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (20 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Asynchronous serial parameter line, idle high |
| trig | input | 1 | Run trigger, rising edge starts a run |
| mux_token | output | 1 | Token into the multiplexer shift register |
| mux_phi1 | output | 1 | First shift-clock phase |
| mux_phi2 | output | 1 | Second shift-clock phase |
| adc_conv | output | 1 | Conversion strobe to the converter |
| fifo_wr | output | 1 | Write strobe to the sample buffer |
| busy | output | 1 | High for the duration of a run |

## Verification
The hardest case to reach is a full frame arriving while a run is in flight. The new values must wait and then land cleanly for the next trigger. The stimulus starts a long run of 128 ticks at a 10-cycle period and sends a complete frame through the serial line during it. It then checks that the current run keeps the old timing and that the following run uses the new one. A second hard case is frame realignment after a corrupt stop bit. The bench sends two good bytes, then a bad byte, then a full frame. A receiver that failed to restart at byte 0 would assemble a tick count and period that the scoreboard rejects.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int unsigned DW          = 8;
  localparam int unsigned CNT_W       = 11;
  localparam int unsigned PW          = 10;
  localparam int unsigned MAX_STROBES = 8;
  localparam int unsigned SW          = $clog2(MAX_STROBES + 1);
  localparam int unsigned STROBE_GAP  = 2;
  localparam int unsigned FRAME_BYTES = 5;

  typedef struct packed {
    logic [PW-1:0]    period;
    logic [DW-1:0]    delay;
    logic [SW-1:0]    nstrobe;
    logic [CNT_W-1:0] count;
  } seq_cfg_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/mrs_uart_rx.sv
module mrs_uart_rx
  import mrs_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_in,
  output logic          byte_vld,
  output logic          byte_err,
  output logic [DW-1:0] byte_data
);
  localparam int unsigned CW   = $clog2(CLKS_PER_BIT) + 1;
  localparam int unsigned HALF = CLKS_PER_BIT / 2;
  localparam logic [CW-1:0] BIT_END  = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_END = CW'(HALF - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line, line_prev;
  rx_state_e              state;
  logic [CW-1:0]          cnt;
  logic [2:0]             bit_idx;
  logic [DW-1:0]          shreg;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= ser_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign line = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      line_prev <= 1'b1;
      byte_vld  <= 1'b0;
      byte_err  <= 1'b0;
    end else begin
      line_prev <= line;
      byte_vld  <= 1'b0;
      byte_err  <= 1'b0;
      case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (line_prev && !line) state <= RX_START;
        end
        RX_START: begin
          if (cnt == HALF_END) begin
            cnt     <= '0;
            bit_idx <= '0;
            state   <= line ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        RX_DATA: begin
          if (cnt == BIT_END) begin
            cnt   <= '0;
            shreg <= {line, shreg[DW-1:1]};
            if (bit_idx == 3'd7) state <= RX_STOP;
            bit_idx <= bit_idx + 3'd1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        RX_STOP: begin
          if (cnt == BIT_END) begin
            cnt      <= '0;
            byte_vld <= line;
            byte_err <= !line;
            state    <= RX_IDLE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign byte_data = shreg;
endmodule

// File: rtl/mrs_param_frame.sv
module mrs_param_frame
  import mrs_pkg::*;
#(
  parameter int unsigned MIN_TICK = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic          byte_err,
  input  logic [DW-1:0] byte_data,
  input  logic          run,
  output seq_cfg_t      cfg
);
  localparam int unsigned IW   = $clog2(FRAME_BYTES);
  localparam int unsigned HI_W = CNT_W - DW;
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BYTES - 1);
  localparam logic [PW-1:0] GAP_V    = PW'(STROBE_GAP);
  localparam logic [PW-1:0] MIN_V    = PW'(MIN_TICK);

  logic [IW-1:0]          idx;
  logic [DW-1:0]          slot [FRAME_BYTES-1];
  logic                   pending;
  seq_cfg_t               staged, assembled;
  logic [SW-1:0]          s_clamped;
  logic [PW-1:0]          need, p_int;

  always_comb begin
    if (byte_data == '0)
      s_clamped = SW'(1);
    else if (byte_data > DW'(MAX_STROBES))
      s_clamped = SW'(MAX_STROBES);
    else
      s_clamped = byte_data[SW-1:0];
    need  = PW'(slot[3]) + PW'(s_clamped) * GAP_V;
    p_int = (PW'(slot[0]) > MIN_V) ? PW'(slot[0]) : MIN_V;
    assembled.period  = (need > p_int) ? need : p_int;
    assembled.delay   = slot[3];
    assembled.nstrobe = s_clamped;
    assembled.count   = {slot[2][HI_W-1:0], slot[1]};
  end

  genvar g;
  generate
    for (g = 0; g < FRAME_BYTES - 1; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n)
          slot[g] <= '0;
        else if (byte_vld && idx == IW'(g))
          slot[g] <= byte_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx         <= '0;
      pending     <= 1'b0;
      staged      <= '0;
      cfg.period  <= MIN_V;
      cfg.delay   <= DW'(2);
      cfg.nstrobe <= SW'(1);
      cfg.count   <= CNT_W'(128);
    end else begin
      if (pending && !run) begin
        cfg     <= staged;
        pending <= 1'b0;
      end
      if (byte_err) begin
        idx <= '0;
      end else if (byte_vld) begin
        if (idx == LAST_IDX) begin
          idx     <= '0;
          staged  <= assembled;
          pending <= 1'b1;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mrs_tick_engine.sv
module mrs_tick_engine
  import mrs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     trig,
  input  seq_cfg_t cfg,
  output logic     run,
  output logic     token_o,
  output logic     phi1_o,
  output logic     phi2_o,
  output logic     conv_o,
  output logic     wr_o,
  output logic     busy_o
);
  localparam logic [PW-1:0] GAP_V = PW'(STROBE_GAP);

  logic             trig_q;
  logic             start;
  logic [PW-1:0]    t;
  logic [CNT_W-1:0] n;
  logic [PW-1:0]    half, off, slot_idx;
  logic             last_phase, last_tick, in_win;
  logic             token_n, phi1_n, phi2_n, conv_n;

  assign start = trig && !trig_q && !run && (cfg.count != '0);

  always_comb begin
    half       = cfg.period >> 1;
    last_phase = (t == cfg.period - PW'(1));
    last_tick  = (n == cfg.count - CNT_W'(1));
    in_win     = (t >= PW'(cfg.delay));
    off        = t - PW'(cfg.delay);
    slot_idx   = off / GAP_V;
    token_n    = run && (n == '0) && (t < half);
    phi1_n     = run && (t >= PW'(1)) && (t < half);
    phi2_n     = run && (t > half);
    conv_n     = run && in_win && ((off % GAP_V) == '0) &&
                 (slot_idx < PW'(cfg.nstrobe));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      run    <= 1'b0;
      t      <= '0;
      n      <= '0;
    end else begin
      trig_q <= trig;
      if (start) begin
        run <= 1'b1;
        t   <= '0;
        n   <= '0;
      end else if (run) begin
        if (last_phase) begin
          t <= '0;
          if (last_tick) run <= 1'b0;
          else           n   <= n + CNT_W'(1);
        end else begin
          t <= t + PW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      token_o <= 1'b0;
      phi1_o  <= 1'b0;
      phi2_o  <= 1'b0;
      conv_o  <= 1'b0;
      wr_o    <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      token_o <= token_n;
      phi1_o  <= phi1_n;
      phi2_o  <= phi2_n;
      conv_o  <= conv_n;
      wr_o    <= conv_o;
      busy_o  <= run;
    end
  end
endmodule

// File: rtl/mux_readout_seq.sv
module mux_readout_seq
  import mrs_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned MIN_TICK     = 8,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  input  logic trig,
  output logic mux_token,
  output logic mux_phi1,
  output logic mux_phi2,
  output logic adc_conv,
  output logic fifo_wr,
  output logic busy
);
  logic          rx_vld, rx_err, run;
  logic [DW-1:0] rx_byte;
  seq_cfg_t      cfg;

  mrs_uart_rx #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_in   (ser_in),
    .byte_vld (rx_vld),
    .byte_err (rx_err),
    .byte_data(rx_byte)
  );

  mrs_param_frame #(
    .MIN_TICK(MIN_TICK)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_vld (rx_vld),
    .byte_err (rx_err),
    .byte_data(rx_byte),
    .run      (run),
    .cfg      (cfg)
  );

  mrs_tick_engine u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (trig),
    .cfg    (cfg),
    .run    (run),
    .token_o(mux_token),
    .phi1_o (mux_phi1),
    .phi2_o (mux_phi2),
    .conv_o (adc_conv),
    .wr_o   (fifo_wr),
    .busy_o (busy)
  );
endmodule

// File: rtl/mrs_checker.sv
module mrs_checker (
  input logic clk,
  input logic rst_n,
  input logic mux_token,
  input logic mux_phi1,
  input logic mux_phi2,
  input logic adc_conv,
  input logic fifo_wr,
  input logic busy
);
  a_r7_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(mux_phi1 && mux_phi2));

  a_r7_gap_after_phi1: assert property (@(posedge clk) disable iff (!rst_n)
    mux_phi1 |=> !mux_phi2);

  a_r7_gap_after_phi2: assert property (@(posedge clk) disable iff (!rst_n)
    mux_phi2 |=> !mux_phi1);

  a_r8_conv_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |=> !adc_conv);

  a_r9_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |=> fifo_wr);

  a_r9_write_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(adc_conv));

  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mux_token || mux_phi1 || mux_phi2 || adc_conv || fifo_wr));

  a_r6_token_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mux_token);

  a_r6_token_only_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mux_token) |-> $rose(busy));
endmodule

bind mux_readout_seq mrs_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mux_token(mux_token),
  .mux_phi1 (mux_phi1),
  .mux_phi2 (mux_phi2),
  .adc_conv (adc_conv),
  .fifo_wr  (fifo_wr),
  .busy     (busy)
);

// File: tb/mux_readout_seq_tb.sv
`timescale 1ns/1ps
module mux_readout_seq_tb;
  localparam int CLK_PERIOD = 50;
  localparam int CPB        = 16;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0, rst_n = 1'b0, ser_in = 1'b1, trig = 1'b0;
  logic mux_token, mux_phi1, mux_phi2, adc_conv, fifo_wr, busy;

  mux_readout_seq #(.CLKS_PER_BIT(CPB)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .trig(trig),
    .mux_token(mux_token), .mux_phi1(mux_phi1), .mux_phi2(mux_phi2),
    .adc_conv(adc_conv), .fifo_wr(fifo_wr), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int e_p = 8, e_d = 2, e_s = 1, e_n = 128;
  int qexp[$];
  int j = 0, err_tok = 0, err_phi = 0, err_wr = 0, runs_done = 0;
  bit bprev = 1'b0;
  string cur_tag = "R11";

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // expected effective parameters from raw frame bytes (R2, R5, R8)
  task automatic load_exp(int b0, int b1, int b2, int b3, int b4);
    int s;
    s   = (b4 == 0) ? 1 : ((b4 > 8) ? 8 : b4);
    e_s = s;
    e_d = b3;
    e_n = ((b2 & 7) << 8) | b1;
    e_p = b0;
    if (e_p < 8) e_p = 8;
    if (e_p < b3 + 2 * s) e_p = b3 + 2 * s;
  endtask

  task automatic send_byte(int b, bit good);
    ser_in = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_in = b[i];
      repeat (CPB) @(negedge clk);
    end
    ser_in = good;
    repeat (CPB) @(negedge clk);
    ser_in = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic send_frame(int b0, int b1, int b2, int b3, int b4);
    send_byte(b0, 1'b1); send_byte(b1, 1'b1); send_byte(b2, 1'b1);
    send_byte(b3, 1'b1); send_byte(b4, 1'b1);
    repeat (4) @(negedge clk);
  endtask

  // driver: pushes expected strobe positions, then triggers a run
  task automatic run_seq(bit extra_trig, string tag);
    int r;
    cur_tag = tag;
    err_tok = 0; err_phi = 0; err_wr = 0;
    qexp.delete();
    for (int n = 0; n < e_n; n++)
      for (int k = 0; k < e_s; k++)
        qexp.push_back(n * e_p + e_d + 2 * k);
    r = runs_done;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    chk(busy == 1'b0, "R4", "busy one cycle after trigger edge", busy, 0);
    @(negedge clk);
    chk(busy == 1'b1, "R4", "busy two cycles after trigger edge", busy, 1);
    if (extra_trig) begin
      repeat (5) @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
    end
    wait (runs_done != r);
    repeat (3) @(negedge clk);
  endtask

  // monitor: compares outputs against the model while busy
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        int t, n;
        bit x_tok, x_p1, x_p2, x_wr;
        t = j % e_p;
        n = j / e_p;
        x_tok = (n == 0) && (t < e_p / 2);
        x_p1  = (t >= 1) && (t < e_p / 2);
        x_p2  = (t >= e_p / 2 + 1);
        x_wr  = (t >= e_d + 1) && (((t - 1 - e_d) % 2) == 0) &&
                (((t - 1 - e_d) / 2) < e_s);
        if (mux_token != x_tok) err_tok++;
        if (mux_phi1 != x_p1 || mux_phi2 != x_p2) err_phi++;
        if (fifo_wr != x_wr) err_wr++;
        if (adc_conv) begin
          if (qexp.size() == 0) chk(1'b0, "R8", "unexpected conversion strobe", j, -1);
          else begin
            int e;
            e = qexp.pop_front();
            chk(e == j, "R8", "conversion strobe position", j, e);
          end
        end
        j++;
      end
      if (bprev && !busy) begin
        chk(j == e_n * e_p, {"R10 ", cur_tag}, "busy length", j, e_n * e_p);
        chk(err_tok == 0, {"R6 ", cur_tag}, "token mismatches", err_tok, 0);
        chk(err_phi == 0, {"R7 ", cur_tag}, "phase clock mismatches", err_phi, 0);
        chk(err_wr == 0, {"R9 ", cur_tag}, "write strobe mismatches", err_wr, 0);
        chk(qexp.size() == 0, {"R8 ", cur_tag}, "missing strobes", qexp.size(), 0);
        j = 0;
        runs_done++;
      end
      bprev = busy;
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    chk(1'b0, "R10", "watchdog: run never finished", 0, 1);
    summary();
  end

  initial begin
    int seen;
    repeat (4) @(negedge clk);
    chk({mux_token, mux_phi1, mux_phi2, adc_conv, fifo_wr, busy} == 6'b0,
        "R11", "outputs in reset", {mux_token, mux_phi1, mux_phi2, adc_conv, fifo_wr, busy}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 defaults: interval 8, count 128, delay 2, one strobe
    load_exp(8, 128, 0, 2, 1);
    run_seq(1'b0, "R11");

    // R2 R5: three strobes per tick, interval 10
    send_frame(10, 5, 0, 3, 3); load_exp(10, 5, 0, 3, 3);
    run_seq(1'b0, "R2");

    // R5: interval below 8 clamped
    send_frame(3, 4, 0, 1, 1); load_exp(3, 4, 0, 1, 1);
    run_seq(1'b0, "R5 min");

    // R5: period stretched by delay + 2*strobes
    send_frame(8, 3, 0, 6, 4); load_exp(8, 3, 0, 6, 4);
    run_seq(1'b0, "R5 stretch");

    // R8: zero strobes taken as one, twelve taken as eight
    send_frame(8, 2, 0, 0, 0); load_exp(8, 2, 0, 0, 0);
    run_seq(1'b0, "R8 zero");
    send_frame(20, 3, 0, 0, 12); load_exp(20, 3, 0, 0, 12);
    run_seq(1'b0, "R8 max");

    // R2: upper bits of byte 2 ignored, odd period
    send_frame(9, 3, 8'hF8, 1, 2); load_exp(9, 3, 8'hF8, 1, 2);
    run_seq(1'b0, "R2 hibits");

    // R4: second trigger during run ignored
    run_seq(1'b1, "R4 retrig");

    // R3: frame arriving mid-run waits for the run to end
    send_frame(10, 128, 0, 3, 2); load_exp(10, 128, 0, 3, 2);
    fork
      run_seq(1'b0, "R3 inflight");
      begin
        repeat (30) @(negedge clk);
        send_frame(8, 6, 0, 1, 1);
      end
    join
    load_exp(8, 6, 0, 1, 1);
    run_seq(1'b0, "R3 next");

    // R1: bad stop bit drops the partial frame
    send_byte(12, 1'b1); send_byte(2, 1'b1); send_byte(8'h55, 1'b0);
    send_frame(11, 4, 0, 2, 2); load_exp(11, 4, 0, 2, 2);
    run_seq(1'b0, "R1 resync");

    // R4: count zero makes a trigger ignored
    send_frame(8, 0, 0, 2, 1);
    seen = 0;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (busy || adc_conv) seen++;
    end
    chk(seen == 0, "R4", "zero count trigger ignored", seen, 0);

    summary();
  end
endmodule